// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block runs the hardware side of entering an exception handler on a 32-bit embedded core. It watches four kinds of request: a maskable interrupt that carries a vector from the interrupt controller, a non-maskable interrupt, a break trap and a bus fault that carries its own vector and faulting address. When the block is idle it picks one request and latches a snapshot of the special registers it needs. In the next cycle it issues every register write-back in one strobe: the return address, the exception status word, the new status word, the stack-pointer swap, the fault address and the delay-slot clear.

After that it reads the handler address from the vector table through a valid/ready read port with a registered response. The returned word goes to the program counter together with a one-cycle done pulse. The surrounding core holds its special registers stable while `busy` is high and applies the write strobes.

Status bit positions are parameters. The defaults put the interrupt-enable flag at bit 6, the user-mode flag at bit 8 and the NMI-enable flag at bit 30.

Top module: `excEntrySeq`

## Requirements
- R1: A maskable interrupt is taken only when `irqReq` is high, status bit I_BIT (default 6) is set and `irqLock` is low. Otherwise it is ignored: `busy` stays low and no write strobe rises.
- R2: An NMI is taken only when status bit M_BIT (default 30) is set. When an NMI is taken, the new status word has M_BIT cleared.
- R3: Requests are sampled only while idle. Priority is bus fault, then break, then NMI, then maskable interrupt. Requests that arrive during a running sequence start nothing, and each sequence produces exactly one write-back cycle and one done pulse.
- R4: The vector is `trapVec` for a break, 0 for an NMI, `faultVec` for a bus fault and `irqVec` for a maskable interrupt.
- R5: The return address is the captured PC minus the captured delay-slot count. It is written through `nrpWe` for an NMI and through `erpWe` for every other cause. `dslotClr` pulses in the write-back cycle when the count was nonzero.
- R6: `exsOut` holds the 8-bit vector in bits [15:8], and all its other bits are zero.
- R7: When status bit U_BIT (default 8) was set, `uspOut` receives the old stack pointer and `spOut` receives the kernel stack pointer, with `uspWe` and `spWe` high. When U_BIT was clear, both enables stay low.
- R8: The new status word is old[31:30] kept in place, old[19:0] moved to bits [29:10] and bits [9:0] zero.
- R9: The read request goes out at `curEbp + 4*vector`. `memReqValid` and `memAddr` stay unchanged until `memReqReady` is seen.
- R10: When the registered response arrives, the following cycle raises `pcWe` with `pcOut` equal to the returned word, together with a one-cycle `done`. After that the block is idle.
- R11: On a bus fault `edaWe` rises in the write-back cycle with `edaOut` equal to `faultAddr`. It stays low for every other cause.
- R12: Every write-back strobe (R5, R6, R7, R8, R11) is active in the single cycle after the accepting edge, and the read request starts in the cycle after that. After reset the block is idle and no strobe or request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Maskable interrupt pending |
| irqVec | input | 8 | Vector from interrupt controller |
| nmiReq | input | 1 | Non-maskable interrupt pending |
| brkReq | input | 1 | Break trap pending |
| busFaultReq | input | 1 | Bus fault pending |
| faultVec | input | 8 | Vector supplied with the bus fault |
| faultAddr | input | 32 | Faulting address |
| trapVec | input | 8 | Programmable break vector |
| irqLock | input | 1 | Maskable interrupts locked out |
| curPc | input | 32 | Current program counter |
| curSp | input | 32 | Current stack pointer |
| curKsp | input | 32 | Kernel stack pointer |
| curCcs | input | 32 | Current status word |
| curEbp | input | 32 | Vector table base |
| curDslot | input | 2 | Delay-slot count at entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pcWe | output | 1 | PC write strobe |
| pcOut | output | 32 | New PC (handler address) |
| spWe | output | 1 | Stack pointer write strobe |
| spOut | output | 32 | New stack pointer |
| uspWe | output | 1 | User stack pointer write strobe |
| uspOut | output | 32 | Saved user stack pointer |
| ccsWe | output | 1 | Status word write strobe |
| ccsOut | output | 32 | New status word |
| erpWe | output | 1 | Exception return register write strobe |
| erpOut | output | 32 | Exception return address |
| nrpWe | output | 1 | NMI return register write strobe |
| nrpOut | output | 32 | NMI return address |
| exsWe | output | 1 | Exception status write strobe |
| exsOut | output | 32 | Exception status word |
| edaWe | output | 1 | Fault address register write strobe |
| edaOut | output | 32 | Faulting address |
| dslotClr | output | 1 | Clear delay-slot count |
| memReqValid | output | 1 | Vector read request valid |
| memReqReady | input | 1 | Vector read request accepted |
| memAddr | output | 32 | Vector read address |
| memRspValid | input | 1 | Read response valid (registered) |
| memRspData | input | 32 | Read response data |

## Verification
A wrongly latched cause or vector shows up in the write-back cycle, one clock after acceptance. It appears as a strobe on the wrong return register, a wrong field in `exsOut`, or a wrong read address in the following cycle. A status-shift or stack-swap fault is visible on `ccsOut`, `spOut` and `uspOut` in that same cycle. A sequencing fault, such as a lost response, a repeated write-back or a restart during a busy sequence, shows on `done` and `pcWe` within a few cycles of the response. The sweep covers every request combination against every enable, lock, user-mode and delay-slot setting, so each arbitration and fix-up path is exercised.

// File: rtl/excPkg.sv
package excPkg;
  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_IRQ,
    CAUSE_NMI,
    CAUSE_BRK,
    CAUSE_BUS
  } causeE;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;    // latch snapshot and chosen cause
    causeE cause;
    logic  writeBack;  // single write-back cycle
    logic  rspLatch;   // latch memory response
    logic  finish;     // load PC, done pulse
  } strobeT;
endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   irqReq,
  input  logic   nmiReq,
  input  logic   brkReq,
  input  logic   busFaultReq,
  input  logic   irqLock,
  input  logic   iFlag,
  input  logic   mFlag,
  input  logic   memReqReady,
  input  logic   memRspValid,
  output logic   memReqValid,
  output logic   busy,
  output strobeT strobe
);
  typedef enum logic [2:0] {S_IDLE, S_WB, S_REQ, S_WAIT, S_FIN} stateE;
  stateE state, stateNxt;
  causeE pick;

  always_comb begin
    if (busFaultReq)               pick = CAUSE_BUS;
    else if (brkReq)               pick = CAUSE_BRK;
    else if (nmiReq && mFlag)      pick = CAUSE_NMI;
    else if (irqReq && iFlag && !irqLock) pick = CAUSE_IRQ;
    else                           pick = CAUSE_NONE;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE: if (pick != CAUSE_NONE) stateNxt = S_WB;
      S_WB:   stateNxt = S_REQ;
      S_REQ:  if (memReqReady) stateNxt = S_WAIT;
      S_WAIT: if (memRspValid) stateNxt = S_FIN;
      S_FIN:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.capture   = (state == S_IDLE) && (pick != CAUSE_NONE);
    strobe.cause     = pick;
    strobe.writeBack = (state == S_WB);
    strobe.rspLatch  = (state == S_WAIT) && memRspValid;
    strobe.finish    = (state == S_FIN);
  end

  assign memReqValid = (state == S_REQ);
  assign busy        = (state != S_IDLE);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);
  // R3
  single_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strobe.finish |=> busy);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !busy);
  // R12
  wb_then_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeBack |=> memReqValid);
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int DSLOT_W    = 2,
  parameter int M_BIT      = 30,
  parameter int U_BIT      = 8,
  parameter int BANK_SHIFT = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic [VEC_W-1:0]   irqVec,
  input  logic [VEC_W-1:0]   faultVec,
  input  logic [VEC_W-1:0]   trapVec,
  input  logic [31:0]        faultAddr,
  input  logic [31:0]        curPc,
  input  logic [31:0]        curSp,
  input  logic [31:0]        curKsp,
  input  logic [31:0]        curCcs,
  input  logic [31:0]        curEbp,
  input  logic [DSLOT_W-1:0] curDslot,
  input  logic [31:0]        memRspData,
  output logic               pcWe,
  output logic [31:0]        pcOut,
  output logic               spWe,
  output logic [31:0]        spOut,
  output logic               uspWe,
  output logic [31:0]        uspOut,
  output logic               ccsWe,
  output logic [31:0]        ccsOut,
  output logic               erpWe,
  output logic [31:0]        erpOut,
  output logic               nrpWe,
  output logic [31:0]        nrpOut,
  output logic               exsWe,
  output logic [31:0]        exsOut,
  output logic               edaWe,
  output logic [31:0]        edaOut,
  output logic               dslotClr,
  output logic [31:0]        memAddr
);
  localparam logic [31:0] TOP_MASK = 32'hC000_0000;
  localparam int          EXS_LO   = 8;

  causeE               causeQ;
  logic [VEC_W-1:0]    vecQ, vecSel;
  logic [31:0]         pcQ, spQ, kspQ, ccsQ, ebpQ, faultQ, rspQ;
  logic [DSLOT_W-1:0]  dslotQ;
  logic [31:0]         retAddr, shifted, newCcs;

  always_comb begin
    case (strobe.cause)
      CAUSE_BRK: vecSel = trapVec;
      CAUSE_BUS: vecSel = faultVec;
      CAUSE_IRQ: vecSel = irqVec;
      default:   vecSel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= CAUSE_NONE;
      vecQ   <= '0;
      pcQ    <= '0;
      spQ    <= '0;
      kspQ   <= '0;
      ccsQ   <= '0;
      ebpQ   <= '0;
      faultQ <= '0;
      dslotQ <= '0;
      rspQ   <= '0;
    end else begin
      if (strobe.capture) begin
        causeQ <= strobe.cause;
        vecQ   <= vecSel;
        pcQ    <= curPc;
        spQ    <= curSp;
        kspQ   <= curKsp;
        ccsQ   <= curCcs;
        ebpQ   <= curEbp;
        faultQ <= faultAddr;
        dslotQ <= curDslot;
      end
      if (strobe.rspLatch) rspQ <= memRspData;
    end
  end

  assign retAddr = pcQ - {{(32-DSLOT_W){1'b0}}, dslotQ};
  assign shifted = (ccsQ << BANK_SHIFT) & ~TOP_MASK;

  always_comb begin
    newCcs = (ccsQ & TOP_MASK) | shifted;
    if (causeQ == CAUSE_NMI) newCcs[M_BIT] = 1'b0;
  end

  assign erpWe    = strobe.writeBack && (causeQ != CAUSE_NMI);
  assign nrpWe    = strobe.writeBack && (causeQ == CAUSE_NMI);
  assign erpOut   = retAddr;
  assign nrpOut   = retAddr;
  assign exsWe    = strobe.writeBack;
  assign exsOut   = {{(32-EXS_LO-8){1'b0}}, 8'(vecQ), {EXS_LO{1'b0}}};
  assign ccsWe    = strobe.writeBack;
  assign ccsOut   = newCcs;
  assign spWe     = strobe.writeBack && ccsQ[U_BIT];
  assign uspWe    = strobe.writeBack && ccsQ[U_BIT];
  assign spOut    = kspQ;
  assign uspOut   = spQ;
  assign edaWe    = strobe.writeBack && (causeQ == CAUSE_BUS);
  assign edaOut   = faultQ;
  assign dslotClr = strobe.writeBack && (dslotQ != '0);
  assign memAddr  = ebpQ + {{(30-VEC_W){1'b0}}, vecQ, 2'b00};
  assign pcWe     = strobe.finish;
  assign pcOut    = rspQ;

  // R2
  nmi_mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    nrpWe |-> !ccsOut[M_BIT]);
  // R8
  low_bank_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ccsWe |-> (ccsOut[BANK_SHIFT-1:0] == '0));
  // R6
  exs_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    exsWe |-> (exsOut[31:16] == '0) && (exsOut[7:0] == '0));
  // R10
  pc_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcWe |-> $past(strobe.rspLatch));
  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeBack |=> $stable(memAddr));
endmodule

// File: rtl/excEntrySeq.sv
module excEntrySeq
  import excPkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int DSLOT_W    = 2,
  parameter int I_BIT      = 6,
  parameter int M_BIT      = 30,
  parameter int U_BIT      = 8,
  parameter int BANK_SHIFT = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               irqReq,
  input  logic [VEC_W-1:0]   irqVec,
  input  logic               nmiReq,
  input  logic               brkReq,
  input  logic               busFaultReq,
  input  logic [VEC_W-1:0]   faultVec,
  input  logic [31:0]        faultAddr,
  input  logic [VEC_W-1:0]   trapVec,
  input  logic               irqLock,
  input  logic [31:0]        curPc,
  input  logic [31:0]        curSp,
  input  logic [31:0]        curKsp,
  input  logic [31:0]        curCcs,
  input  logic [31:0]        curEbp,
  input  logic [DSLOT_W-1:0] curDslot,
  output logic               busy,
  output logic               done,
  output logic               pcWe,
  output logic [31:0]        pcOut,
  output logic               spWe,
  output logic [31:0]        spOut,
  output logic               uspWe,
  output logic [31:0]        uspOut,
  output logic               ccsWe,
  output logic [31:0]        ccsOut,
  output logic               erpWe,
  output logic [31:0]        erpOut,
  output logic               nrpWe,
  output logic [31:0]        nrpOut,
  output logic               exsWe,
  output logic [31:0]        exsOut,
  output logic               edaWe,
  output logic [31:0]        edaOut,
  output logic               dslotClr,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [31:0]        memAddr,
  input  logic               memRspValid,
  input  logic [31:0]        memRspData
);
  strobeT strobe;

  excCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .irqReq(irqReq), .nmiReq(nmiReq), .brkReq(brkReq),
    .busFaultReq(busFaultReq), .irqLock(irqLock),
    .iFlag(curCcs[I_BIT]), .mFlag(curCcs[M_BIT]),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memReqValid(memReqValid), .busy(busy), .strobe(strobe)
  );

  excDatapath #(
    .VEC_W(VEC_W), .DSLOT_W(DSLOT_W), .M_BIT(M_BIT),
    .U_BIT(U_BIT), .BANK_SHIFT(BANK_SHIFT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .irqVec(irqVec), .faultVec(faultVec), .trapVec(trapVec),
    .faultAddr(faultAddr), .curPc(curPc), .curSp(curSp),
    .curKsp(curKsp), .curCcs(curCcs), .curEbp(curEbp),
    .curDslot(curDslot), .memRspData(memRspData),
    .pcWe(pcWe), .pcOut(pcOut), .spWe(spWe), .spOut(spOut),
    .uspWe(uspWe), .uspOut(uspOut), .ccsWe(ccsWe), .ccsOut(ccsOut),
    .erpWe(erpWe), .erpOut(erpOut), .nrpWe(nrpWe), .nrpOut(nrpOut),
    .exsWe(exsWe), .exsOut(exsOut), .edaWe(edaWe), .edaOut(edaOut),
    .dslotClr(dslotClr), .memAddr(memAddr)
  );

  assign done = strobe.finish;

  // R11
  eda_only_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    edaWe |-> erpWe && !nrpWe);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memAddr));
endmodule

// File: tb/excEntrySeq_tb.sv
`timescale 1ns/1ps
module excEntrySeq_tb_top;
  localparam int I_B = 6;
  localparam int M_B = 30;
  localparam int U_B = 8;
  localparam logic [31:0] KEY = 32'h5A5A_F00F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReq = 0, nmiReq = 0, brkReq = 0, busFaultReq = 0, irqLock = 0;
  logic [7:0] irqVec = '0, faultVec = '0, trapVec = '0;
  logic [31:0] faultAddr = '0, curPc = '0, curSp = '0, curKsp = '0, curCcs = '0, curEbp = '0;
  logic [1:0] curDslot = '0;
  logic busy, done, pcWe, spWe, uspWe, ccsWe, erpWe, nrpWe, exsWe, edaWe, dslotClr;
  logic [31:0] pcOut, spOut, uspOut, ccsOut, erpOut, nrpOut, exsOut, edaOut, memAddr;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  excEntrySeq dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqVec(irqVec), .nmiReq(nmiReq),
    .brkReq(brkReq), .busFaultReq(busFaultReq), .faultVec(faultVec),
    .faultAddr(faultAddr), .trapVec(trapVec), .irqLock(irqLock),
    .curPc(curPc), .curSp(curSp), .curKsp(curKsp), .curCcs(curCcs),
    .curEbp(curEbp), .curDslot(curDslot), .busy(busy), .done(done),
    .pcWe(pcWe), .pcOut(pcOut), .spWe(spWe), .spOut(spOut),
    .uspWe(uspWe), .uspOut(uspOut), .ccsWe(ccsWe), .ccsOut(ccsOut),
    .erpWe(erpWe), .erpOut(erpOut), .nrpWe(nrpWe), .nrpOut(nrpOut),
    .exsWe(exsWe), .exsOut(exsOut), .edaWe(edaWe), .edaOut(edaOut),
    .dslotClr(dslotClr), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memAddr(memAddr), .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // memory model: ready toggles, registered response
  always @(posedge clk) begin
    memReqReady <= ~memReqReady;
    memRspValid <= memReqValid && memReqReady;
    memRspData  <= memAddr ^ KEY;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runCase(input int idx, input bit rIrq, rNmi, rBrk, rBus,
                         input bit ien, men, lock, usr, input logic [1:0] ds);
    int cause;  // 0 none 1 irq 2 nmi 3 brk 4 bus
    logic [31:0] ccs, expCcs, tmp, expRet, expAddr;
    logic [7:0] expVec;
    bit sawAddr, sawDone;
    int extraWb;
    ccs = 32'h9ABC_DE00 ^ (idx * 32'h0101_0101);
    ccs[I_B] = ien; ccs[M_B] = men; ccs[U_B] = usr;
    @(negedge clk);
    curCcs = ccs; curPc = 32'h1000_0000 + idx * 8 + 3; curSp = 32'h2000_0000 + idx;
    curKsp = 32'h3000_0000 + idx; curEbp = 32'h4000_0000 + idx * 16;
    curDslot = ds; irqLock = lock; faultAddr = 32'hDEAD_0000 + idx;
    irqVec = 8'(idx) ^ 8'h40; faultVec = 8'h3C; trapVec = 8'h21;
    irqReq = rIrq; nmiReq = rNmi; brkReq = rBrk; busFaultReq = rBus;
    if (rBus) cause = 4; else if (rBrk) cause = 3; else if (rNmi && men) cause = 2;
    else if (rIrq && ien && !lock) cause = 1; else cause = 0;
    case (cause)
      1: expVec = irqVec; 2: expVec = 8'h00; 3: expVec = trapVec; 4: expVec = faultVec;
      default: expVec = 8'h00;
    endcase
    @(negedge clk);
    irqReq = 0; nmiReq = 0; brkReq = 0; busFaultReq = 0;
    if (cause == 0) begin
      chk(!busy && !erpWe && !nrpWe && !ccsWe, "R1/R2 ignored request", {31'b0, busy}, 0);
      return;
    end
    chk(busy, "R12 busy in write-back cycle", {31'b0, busy}, 1);
    expRet = curPc - {30'b0, ds};
    if (cause == 2) begin
      chk(nrpWe && !erpWe && nrpOut == expRet, "R5 NMI return", nrpOut, expRet);
    end else begin
      chk(erpWe && !nrpWe && erpOut == expRet, "R5 return addr", erpOut, expRet);
    end
    chk(dslotClr == (ds != 0), "R5 dslot clear", {31'b0, dslotClr}, {31'b0, ds != 0});
    chk(exsWe && exsOut == {16'b0, expVec, 8'b0}, "R4/R6 status vector", exsOut, {16'b0, expVec, 8'b0});
    tmp = ccs << 12; tmp = tmp >> 2;
    expCcs = ((ccs & 32'hC000_0000) | tmp) & ~32'h3FF;
    if (cause == 2) expCcs[M_B] = 1'b0;
    chk(ccsWe && ccsOut == expCcs, "R8/R2 status shift", ccsOut, expCcs);
    chk(spWe == usr && uspWe == usr, "R7 swap strobes", {31'b0, spWe}, {31'b0, usr});
    if (usr) chk(spOut == curKsp && uspOut == curSp, "R7 swap values", spOut, curKsp);
    chk(edaWe == (cause == 4), "R11 fault strobe", {31'b0, edaWe}, {31'b0, cause == 4});
    if (cause == 4) chk(edaOut == faultAddr, "R11 fault addr", edaOut, faultAddr);
    expAddr = curEbp + {22'b0, expVec, 2'b00};
    sawAddr = 0; sawDone = 0; extraWb = 0;
    for (int c = 0; c < 20 && !sawDone; c++) begin
      busFaultReq = 1; nmiReq = 1;  // must be ignored while busy (R3)
      @(negedge clk);
      if (exsWe || ccsWe) extraWb++;
      if (memReqValid && !sawAddr) begin
        sawAddr = 1;
        chk(memAddr == expAddr, "R9 fetch address", memAddr, expAddr);
      end
      if (done) begin
        sawDone = 1;
        busFaultReq = 0; nmiReq = 0;
        chk(pcWe && pcOut == (expAddr ^ KEY), "R10 handler PC", pcOut, expAddr ^ KEY);
      end
    end
    busFaultReq = 0; nmiReq = 0;
    chk(sawDone, "R10 done seen", {31'b0, sawDone}, 1);
    chk(extraWb == 0, "R3 single write-back", extraWb, 0);
    @(negedge clk);
    chk(!busy && !done, "R3/R10 idle after done", {30'b0, busy, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !memReqValid && !pcWe && !ccsWe && !erpWe, "R12 reset state", {31'b0, busy}, 0);
    rstN = 1'b1;
    for (int m = 0; m < 16; m++)
      for (int f = 0; f < 8; f++)
        for (int u = 0; u < 2; u++)
          for (int d = 0; d < 4; d++)
            runCase(m * 64 + f * 8 + u * 4 + d, m[0], m[1], m[2], m[3],
                    f[0], f[1], f[2], u[0], 2'(d));
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++; testCnt++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule